// File: doc/BRIEF.md
# Payload Loopback with Local Overhead Regeneration

This block sits between a receive framer and a transmit framer on a T1 or E1 serial link. It runs on one bit clock. In normal operation, the outgoing payload bits come from the transmit serial input, and frame timing comes from a free-running local bit and frame counter. When payload loopback is turned on, the payload positions of each outgoing frame carry the receive bit stream instead. The receive frame-start pulse then re-aligns the transmit frame, so the outgoing frame is locked to the incoming one.

Overhead bits are never copied from the receive stream. The block always builds them on the outgoing side:

- **T1:** the F-bit carries the framing pattern, the CRC-6 check bits and the data-link bits.
- **E1:** timeslot 0 carries the alignment word, the multiframe pattern, the CRC-4 bits, the E-bits and the Sa spare bits.

The check bits are computed over the stream that was actually sent. The receive stream is assumed to be already decoded and free of bipolar violations.

Each output is registered, so an output appears one clock after the cycle in which its inputs were presented. `mf_pos` gives the frame number within the multiframe for the bit currently on `tx_bit`.

Top module: `plb_loop`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `tx_bit`, `tx_sync` and `mf_pos` are 0, and loopback is inactive.
- R2: T1 mode (`mode_e1`=0) uses 193-bit frames. Position 0 is the F-bit and positions 1..192 are payload. `tx_sync` is high for exactly the position-0 bit. `mf_pos` counts frames 0..23 and then wraps. The first frame after reset is frame 0.
- R3: E1 mode (`mode_e1`=1) uses 256-bit frames. Positions 0..7 are timeslot 0 and positions 8..255 are payload. `mf_pos` counts frames 0..15.
- R4: With loopback inactive, each payload bit on `tx_bit` equals the `tx_ser_in` value from one clock earlier. `rx_bit` and `rx_sync` have no effect.
- R5: With loopback active, a high `rx_sync` makes that bit position 0 of a new frame, whatever the local count was. `tx_sync` rises one clock later and `mf_pos` advances by one frame.
- R6: Loopback switches on at the first `rx_sync` seen while `lb_en` is high; that bit is position 0. It switches off at the first frame start seen while `lb_en` is low. Without an `rx_sync`, a high `lb_en` has no effect.
- R7: In T1, the F-bit of frames 3, 7, 11, 15, 19 and 23 carries 0, 0, 1, 0, 1, 1 in that order.
- R8: In T1, the F-bit of frames 1, 5, 9, 13, 17 and 21 carries check bits C1..C6, most significant first. They are the CRC (x^6+x+1, initial 0, no inversion) of all bits of the previous 24-frame superframe, with every F-bit taken as 1. The first superframe after reset sends zeros.
- R9: In T1, the F-bit of even frames equals `fdl_bit` from one clock earlier.
- R10: In E1 even frames, timeslot-0 positions 1..7 carry 0,0,1,1,0,1,1.
- R11: In E1 odd frames, position 1 is 1, position 2 is 0, and positions 3..7 carry `sa_bits[0]`..`sa_bits[4]`. Position 0 carries 0,0,1,0,1,1 in frames 1..11, `e_bits[0]` in frame 13 and `e_bits[1]` in frame 15.
- R12: In E1, position 0 of frames 0, 2, 4, 6 (and of 8, 10, 12, 14) carries C1..C4, most significant first. They are the CRC (x^4+x+1, initial 0) of the previous 8-frame half multiframe, with these eight C positions taken as 0. Zeros are sent until the first half multiframe after reset is complete.
- R13: With loopback active, each payload bit equals `rx_bit` from one clock earlier. `tx_ser_in` has no effect, and `rx_bit` never reaches an overhead position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_e1 | input | 1 | 0 = T1 framing, 1 = E1 framing; change only under reset |
| lb_en | input | 1 | Payload loopback request |
| rx_bit | input | 1 | Receive payload stream |
| rx_sync | input | 1 | Receive frame-start pulse, high on the first bit of a frame |
| tx_ser_in | input | 1 | Normal transmit serial data |
| fdl_bit | input | 1 | T1 data-link bit for the current F-bit slot |
| sa_bits | input | 5 | E1 spare bits Sa4..Sa8 |
| e_bits | input | 2 | E1 remote CRC error indications |
| tx_bit | output | 1 | Transmit serial bit |
| tx_sync | output | 1 | High on the first bit of each transmit frame |
| mf_pos | output | 5 | Frame number within the multiframe |

## Verification
The hardest situation to reach is a loopback superframe whose check bits were computed over looped receive data. That requires a full superframe carried under receive timing. It also requires a receive pulse that lands mid-frame and cuts a frame short; a normal framer never produces one.

The stimulus reaches it in four steps:
1. It holds loopback on with a receive pulse train offset from the local count for more than three T1 superframes, and for a full E1 multiframe.
2. It then forces one early receive pulse to truncate a frame.
3. It requests loopback while no receive pulses arrive.
4. It drops the request mid-frame, so the switch-back point is exercised.

// File: rtl/plb_pkg.sv
package plb_pkg;
  localparam int T1_LEN    = 193;
  localparam int E1_LEN    = 256;
  localparam int T1_FRAMES = 24;
  localparam int E1_FRAMES = 16;
  localparam int E1_OH     = 8;
  localparam int CNT_W     = $clog2(E1_LEN);
  localparam int FRM_W     = $clog2(T1_FRAMES);
  localparam int T1_CRC_W  = 6;
  localparam int E1_CRC_W  = 4;
  localparam logic [T1_CRC_W-1:0] T1_POLY = 6'b000011;
  localparam logic [E1_CRC_W-1:0] E1_POLY = 4'b0011;
  // bit k of the six-entry alignment sequence 0,0,1,0,1,1
  localparam logic [5:0] PAT_SIX = 6'b110100;
  // bit p = timeslot-0 position p of the E1 alignment word
  localparam logic [7:0] PAT_FAS = 8'b11011000;
endpackage

// File: rtl/plb_crc.sv
module plb_crc #(
  parameter int W = 6,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         din,
  output logic [W-1:0] acc
);
  logic [W-1:0] acc_q, base, acc_d;
  logic         fb;

  always_comb begin
    base  = clr ? '0 : acc_q;
    fb    = din ^ base[W-1];
    acc_d = {base[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/plb_timing.sv
module plb_timing
  import plb_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int FW = FRM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_e1,
  input  logic          lb_en,
  input  logic          rx_sync,
  output logic [CW-1:0] cur_pos,
  output logic [FW-1:0] cur_frm,
  output logic          fstart,
  output logic          lb_now,
  output logic          lb_act
);
  logic [CW-1:0] cnt_q, cnt_d, len_m1;
  logic [FW-1:0] frm_q, nf_m1;
  logic          realign;

  always_comb begin
    len_m1  = mode_e1 ? CW'(E1_LEN - 1) : CW'(T1_LEN - 1);
    nf_m1   = mode_e1 ? FW'(E1_FRAMES - 1) : FW'(T1_FRAMES - 1);
    realign = rx_sync && (lb_act || lb_en);
    cur_pos = realign ? '0 : cnt_q;
    fstart  = (cur_pos == '0);
    if (fstart) cur_frm = (frm_q >= nf_m1) ? '0 : frm_q + 1'b1;
    else        cur_frm = frm_q;
    if (lb_act) lb_now = fstart ? lb_en : 1'b1;
    else        lb_now = lb_en && rx_sync;
    cnt_d = (cur_pos >= len_m1) ? '0 : cur_pos + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      frm_q  <= '1;
      lb_act <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      frm_q  <= cur_frm;
      lb_act <= lb_now;
    end
  end
endmodule

// File: rtl/plb_ovh.sv
module plb_ovh
  import plb_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int FW = FRM_W
) (
  input  logic                mode_e1,
  input  logic [CW-1:0]       pos,
  input  logic [FW-1:0]       frm,
  input  logic [T1_CRC_W-1:0] crc6,
  input  logic [E1_CRC_W-1:0] crc4,
  input  logic                fdl_bit,
  input  logic [4:0]          sa_bits,
  input  logic [1:0]          e_bits,
  output logic                is_ovh,
  output logic                ovh_bit,
  output logic                sub_en,
  output logic                sub_val
);
  logic [2:0] k6, p3;
  logic [1:0] k4;

  always_comb begin
    k6      = frm[4:2];
    k4      = frm[2:1];
    p3      = pos[2:0];
    ovh_bit = 1'b0;
    if (!mode_e1) begin
      is_ovh  = (pos == '0);
      sub_en  = is_ovh;
      sub_val = 1'b1;
      case (frm[1:0])
        2'b11:   ovh_bit = PAT_SIX[k6];
        2'b01:   ovh_bit = crc6[3'd5 - k6];
        default: ovh_bit = fdl_bit;
      endcase
    end else begin
      is_ovh  = (pos < CW'(E1_OH));
      sub_en  = (pos == '0) && !frm[0];
      sub_val = 1'b0;
      if (!frm[0]) begin
        ovh_bit = (p3 == 3'd0) ? crc4[2'd3 - k4] : PAT_FAS[p3];
      end else begin
        case (p3)
          3'd0: begin
            if (frm <= FW'(11))      ovh_bit = PAT_SIX[frm[3:1]];
            else if (frm == FW'(13)) ovh_bit = e_bits[0];
            else                     ovh_bit = e_bits[1];
          end
          3'd1:    ovh_bit = 1'b1;
          3'd2:    ovh_bit = 1'b0;
          default: ovh_bit = sa_bits[p3 - 3'd3];
        endcase
      end
    end
  end
endmodule

// File: rtl/plb_loop.sv
module plb_loop
  import plb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_e1,
  input  logic             lb_en,
  input  logic             rx_bit,
  input  logic             rx_sync,
  input  logic             tx_ser_in,
  input  logic             fdl_bit,
  input  logic [4:0]       sa_bits,
  input  logic [1:0]       e_bits,
  output logic             tx_bit,
  output logic             tx_sync,
  output logic [FRM_W-1:0] mf_pos
);
  logic [CNT_W-1:0]    cur_pos;
  logic [FRM_W-1:0]    cur_frm;
  logic                fstart, lb_now, lb_act;
  logic                is_ovh, ovh_bit, sub_en, sub_val;
  logic                out_bit, feed, blk;
  logic [T1_CRC_W-1:0] acc6, hold6_q, use6;
  logic [E1_CRC_W-1:0] acc4, hold4_q, use4;
  logic                tx_bit_q, tx_sync_q;
  logic [FRM_W-1:0]    mf_q;

  plb_timing #(.CW(CNT_W), .FW(FRM_W)) u_tim (
    .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1), .lb_en(lb_en),
    .rx_sync(rx_sync), .cur_pos(cur_pos), .cur_frm(cur_frm),
    .fstart(fstart), .lb_now(lb_now), .lb_act(lb_act)
  );

  always_comb begin
    blk  = fstart && (mode_e1 ? (cur_frm[2:0] == 3'd0) : (cur_frm == '0));
    use6 = blk ? acc6 : hold6_q;
    use4 = blk ? acc4 : hold4_q;
  end

  plb_ovh #(.CW(CNT_W), .FW(FRM_W)) u_ovh (
    .mode_e1(mode_e1), .pos(cur_pos), .frm(cur_frm), .crc6(use6), .crc4(use4),
    .fdl_bit(fdl_bit), .sa_bits(sa_bits), .e_bits(e_bits),
    .is_ovh(is_ovh), .ovh_bit(ovh_bit), .sub_en(sub_en), .sub_val(sub_val)
  );

  always_comb begin
    out_bit = is_ovh ? ovh_bit : (lb_now ? rx_bit : tx_ser_in);
    feed    = sub_en ? sub_val : out_bit;
  end

  plb_crc #(.W(T1_CRC_W), .POLY(T1_POLY)) u_crc6 (
    .clk(clk), .rst_n(rst_n), .en(!mode_e1), .clr(blk), .din(feed), .acc(acc6)
  );

  plb_crc #(.W(E1_CRC_W), .POLY(E1_POLY)) u_crc4 (
    .clk(clk), .rst_n(rst_n), .en(mode_e1), .clr(blk), .din(feed), .acc(acc4)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold6_q <= '0;
      hold4_q <= '0;
    end else if (blk) begin
      hold6_q <= use6;
      hold4_q <= use4;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_bit_q  <= 1'b0;
      tx_sync_q <= 1'b0;
      mf_q      <= '0;
    end else begin
      tx_bit_q  <= out_bit;
      tx_sync_q <= fstart;
      mf_q      <= cur_frm;
    end
  end

  assign tx_bit  = tx_bit_q;
  assign tx_sync = tx_sync_q;
  assign mf_pos  = mf_q;
endmodule

// File: rtl/plb_loop_sva.sv
module plb_loop_sva
  import plb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             mode_e1,
  input logic             lb_en,
  input logic             rx_bit,
  input logic             rx_sync,
  input logic             lb_act,
  input logic             lb_now,
  input logic [CNT_W-1:0] cur_pos,
  input logic             tx_bit,
  input logic             tx_sync,
  input logic [FRM_W-1:0] mf_pos
);
  logic [CNT_W:0] ck;
  logic           seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck   <= '0;
      seen <= 1'b0;
    end else if (tx_sync) begin
      ck   <= 1;
      seen <= 1'b1;
    end else if (ck != '1) begin
      ck <= ck + 1'b1;
    end
  end

  a_r2_mf_range: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_e1 |-> mf_pos < FRM_W'(T1_FRAMES));

  a_r3_mf_range: assert property (@(posedge clk) disable iff (!rst_n)
    mode_e1 |-> mf_pos < FRM_W'(E1_FRAMES));

  a_r5_slave_sync: assert property (@(posedge clk) disable iff (!rst_n)
    lb_act && rx_sync |=> tx_sync);

  a_r6_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_act && !(lb_en && rx_sync) |=> !lb_act);

  a_r13_payload_loop: assert property (@(posedge clk) disable iff (!rst_n)
    lb_now && (cur_pos >= (mode_e1 ? CNT_W'(E1_OH) : CNT_W'(1)))
    |=> tx_bit == $past(rx_bit));

  a_r10_fas_word: assert property (@(posedge clk) disable iff (!rst_n)
    seen && mode_e1 && !tx_sync && (ck >= 1) && (ck <= 7) && !mf_pos[0]
    |-> tx_bit == PAT_FAS[ck[2:0]]);
endmodule

bind plb_loop plb_loop_sva u_sva (
  .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1), .lb_en(lb_en),
  .rx_bit(rx_bit), .rx_sync(rx_sync), .lb_act(lb_act), .lb_now(lb_now),
  .cur_pos(cur_pos), .tx_bit(tx_bit), .tx_sync(tx_sync), .mf_pos(mf_pos)
);

// File: tb/tb_plb_loop.sv
`timescale 1ns/1ps
module tb_plb_loop;
  localparam int CLK_NS = 4;

  logic       clk, rst_n, mode_e1, lb_en, rx_bit, rx_sync, tx_ser_in, fdl_bit;
  logic [4:0] sa_bits;
  logic [1:0] e_bits;
  logic       tx_bit, tx_sync;
  logic [4:0] mf_pos;

  plb_loop dut (
    .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1), .lb_en(lb_en), .rx_bit(rx_bit),
    .rx_sync(rx_sync), .tx_ser_in(tx_ser_in), .fdl_bit(fdl_bit), .sa_bits(sa_bits),
    .e_bits(e_bits), .tx_bit(tx_bit), .tx_sync(tx_sync), .mf_pos(mf_pos)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  int n_chk, n_fail, rxc;
  int m_cnt, m_frm, m_lb, m_a6, m_a4, m_h6, m_h4, m_sw;
  bit e_bit, e_sync, have_exp, done;
  int e_mf;
  string tag_bit, tag_sync;

  function automatic int crc_step(int acc, int d, int w, int poly);
    int fb = d ^ ((acc >> (w - 1)) & 1);
    return ((acc << 1) & ((1 << w) - 1)) ^ (fb ? poly : 0);
  endfunction

  function automatic bit six(int k);
    bit pat[6] = '{0, 0, 1, 0, 1, 1};
    return pat[k];
  endfunction

  function automatic bit t1_fbit(int f, int crc, bit fdl);
    if (f % 4 == 3) return six(f / 4);
    if (f % 4 == 1) return bit'((crc >> (5 - f / 4)) & 1);
    return fdl;
  endfunction

  function automatic bit e1_ts0(int f, int p, int crc, logic [4:0] sa, logic [1:0] e);
    bit fas[8] = '{0, 0, 0, 1, 1, 0, 1, 1};
    if (f % 2 == 0) return (p == 0) ? bit'((crc >> (3 - (f % 8) / 2)) & 1) : fas[p];
    if (p == 0) return (f <= 11) ? six((f - 1) / 2) : ((f == 13) ? e[0] : e[1]);
    if (p == 1) return 1'b1;
    if (p == 2) return 1'b0;
    return sa[p - 3];
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int len = mode_e1 ? 256 : 193;
    int nf  = mode_e1 ? 16 : 24;
    bit realign = rx_sync && (m_lb != 0 || lb_en);
    int p = realign ? 0 : m_cnt;
    int f = (p == 0) ? (m_frm + 1) % nf : m_frm;
    int nl;
    bit ovh, b, d;
    if (m_lb == 0) nl = (lb_en && rx_sync) ? 1 : 0;
    else           nl = (p == 0) ? int'(lb_en) : 1;
    if (p == 0) m_sw = (nl != m_lb);
    if (p == 0 && (mode_e1 ? (f % 8 == 0) : (f == 0))) begin
      m_h6 = m_a6; m_h4 = m_a4; m_a6 = 0; m_a4 = 0;
    end
    ovh = mode_e1 ? (p < 8) : (p == 0);
    if (ovh) begin
      b = mode_e1 ? e1_ts0(f, p, m_h4, sa_bits, e_bits) : t1_fbit(f, m_h6, fdl_bit);
      if (!mode_e1) tag_bit = (f % 4 == 3) ? "R7" : (f % 4 == 1) ? "R8" : "R9";
      else tag_bit = (f % 2 == 1) ? "R11" : (p == 0) ? "R12" : "R10";
    end else begin
      b = nl ? rx_bit : tx_ser_in;
      tag_bit = m_sw ? "R6" : (nl ? "R13" : "R4");
    end
    if (mode_e1) begin
      d = (p == 0 && f % 2 == 0) ? 1'b0 : b;
      m_a4 = crc_step(m_a4, d, 4, 3);
    end else begin
      d = (p == 0) ? 1'b1 : b;
      m_a6 = crc_step(m_a6, d, 6, 3);
    end
    tag_sync = realign ? "R5" : (mode_e1 ? "R3" : "R2");
    e_bit = b; e_sync = (p == 0); e_mf = f;
    m_cnt = (p + 1) % len; m_frm = f; m_lb = nl;
  endtask

  task automatic do_reset(bit e1);
    @(negedge clk);
    rst_n = 1'b0; mode_e1 = e1; lb_en = 1'b0; rx_sync = 1'b0;
    repeat (3) @(negedge clk);
    check(tx_bit == 1'b0, "R1", "reset tx_bit", int'(tx_bit), 0);
    check(tx_sync == 1'b0, "R1", "reset tx_sync", int'(tx_sync), 0);
    check(mf_pos == 5'd0, "R1", "reset mf_pos", int'(mf_pos), 0);
    have_exp = 0;
    m_cnt = 0; m_frm = e1 ? 15 : 23; m_lb = 0; m_sw = 0;
    m_a6 = 0; m_a4 = 0; m_h6 = 0; m_h4 = 0;
  endtask

  task automatic run(int n, bit en, bit syncs);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (have_exp) begin
        check(tx_bit == e_bit, tag_bit, "tx_bit", int'(tx_bit), int'(e_bit));
        check(tx_sync == e_sync, tag_sync, "tx_sync", int'(tx_sync), int'(e_sync));
        check(int'(mf_pos) == e_mf, mode_e1 ? "R3" : "R2", "mf_pos", int'(mf_pos), e_mf);
      end
      rst_n = 1'b1;
      lb_en = en;
      rx_bit = 1'($urandom); tx_ser_in = 1'($urandom); fdl_bit = 1'($urandom);
      sa_bits = 5'($urandom); e_bits = 2'($urandom);
      rx_sync = syncs && (rxc == 0);
      rxc = (rxc + 1) % (mode_e1 ? 256 : 193);
      model_step();
      have_exp = 1;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; mode_e1 = 1'b0; lb_en = 1'b0; rx_bit = 1'b0; rx_sync = 1'b0;
    tx_ser_in = 1'b0; fdl_bit = 1'b0; sa_bits = '0; e_bits = '0;
    // T1: local timing with receive pulses present but ignored (R4, R7, R8, R9)
    do_reset(1'b0); rxc = 77;
    run(9400, 1'b0, 1'b1);
    // request without any receive pulse must not start loopback (R6)
    run(600, 1'b1, 1'b0);
    // loopback over more than three superframes (R5, R8, R13)
    run(14500, 1'b1, 1'b1);
    // early receive pulse truncates a frame (R5)
    rxc = 0;
    run(400, 1'b1, 1'b1);
    // drop request mid-frame, switch back at next frame start (R6)
    run(1000, 1'b0, 1'b1);
    // E1 (R3, R10, R11, R12)
    do_reset(1'b1); rxc = 30;
    run(4500, 1'b0, 1'b1);
    run(9000, 1'b1, 1'b1);
    rxc = 0;
    run(300, 1'b1, 1'b1);
    run(1000, 1'b0, 1'b1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule